// File: doc/BRIEF.md
# Hardware Lock Arbiter for Two Multithreaded Cores

This block keeps the state of a set of mutual-exclusion locks that are shared by the hardware threads of two processor cores. Each core runs four threads, so eight threads in all can ask for a lock. A core marks an instruction as an acquire or a release with two flag bits. The flags travel with the lock number and the thread number of the issuing thread.

An acquire of a free lock is granted. An acquire of a held lock answers "suspend". The core then parks that thread instead of letting it spin, and the arbiter records the thread as a waiter. When the owner releases the lock, ownership moves straight to one waiter, chosen round-robin from the thread after the old owner. The core that holds the new owner receives a resume pulse that carries the thread number. This works across cores: a release on one core can wake a thread that lives on the other.

Both cores may issue one request in every cycle. Answers come back one cycle after the request. Wakes that collide on one core are spread over the following cycles.

Top module: `hwl_lock_arbiter`

## Requirements
- R1: After reset, every lock is free, `rsp_valid` and `wake_valid` are 0 on both cores, and `rel_error` is 0.
- R2: On core c, `req_acq_flag`=1 with `req_rel_flag`=0 is an acquire, and `req_acq_flag`=0 with `req_rel_flag`=1 is a release. Both flags set, or neither, is no operation: it produces no response and changes no lock. `req_lock` is a 4-bit lock number (16 locks). `req_tid` is a 3-bit global thread number; threads 0 to 3 belong to core 0 and threads 4 to 7 to core 1.
- R3: An acquire of a free lock gives `rsp_valid`=1 and `rsp_grant`=1 on the same core exactly one cycle later, and the thread becomes the owner.
- R4: An acquire of a lock held by another thread gives `rsp_valid`=1 and `rsp_grant`=0 (suspend) one cycle later, and the thread is recorded as a waiter.
- R5: When the owner releases a lock that has waiters, the new owner is the first waiter found by scanning the thread numbers (owner+1) mod 8, (owner+2) mod 8, and so on. The core that holds that thread (bit 2 of its number) sees `wake_valid`=1 with `wake_tid` equal to that thread one cycle after the release.
- R6: When the owner releases a lock that has no waiters, the lock becomes free and no wake is produced.
- R7: A release by a thread that does not own the lock (including a release of a free lock) changes no lock and produces no wake. It sets `rel_error`, which stays 1 until reset.
- R8: When a release and an acquire for the same lock arrive in the same cycle, the release is handled first. The acquiring thread then joins the waiters in the round-robin scan of R5. If it is chosen, it gets `rsp_grant`=1 and no wake is sent. Otherwise it gets a suspend and the chosen waiter is woken.
- R9: When both cores acquire the same free lock in the same cycle and no release is present, core 0's thread is granted and core 1's thread is suspended.
- R10: At most one wake is issued per core per cycle. Wakes that target one core in the same cycle come out on consecutive cycles, lowest thread number first.
- R11: Operations on different locks in the same cycle do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_acq_flag | input | 2 | Acquire flag, one bit per core |
| req_rel_flag | input | 2 | Release flag, one bit per core |
| req_lock | input | 2x4 | Lock number per core |
| req_tid | input | 2x3 | Global thread number per core |
| rsp_valid | output | 2 | Answer to an acquire from the previous cycle, per core |
| rsp_grant | output | 2 | 1 = granted, 0 = suspend (valid with rsp_valid) |
| wake_valid | output | 2 | Resume pulse per core |
| wake_tid | output | 2x3 | Thread number to resume, per core |
| rel_error | output | 1 | Sticky flag for an illegal release |

## Verification
Three functions can land in the same cycle. First, a release and an acquire can name the same lock. Second, both cores can acquire one free lock. Third, releases of two different locks can each hand off to a thread on the same core, so two wakes compete for one wake port. The bench drives each of these collisions from both cores in one cycle. It judges the outcome by the answer and wake it expects from the round-robin order, computed from thread numbers. A sweep over every lock and every first owner then checks the whole handoff chain through all seven other threads.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
    parameter int HWL_CORES = 2;
    parameter int HWL_TPC   = 4;
    parameter int HWL_LOCKS = 16;

    localparam int HWL_THREADS = HWL_CORES * HWL_TPC;
    localparam int HWL_TIDW    = $clog2(HWL_THREADS);
    localparam int HWL_LIDW    = $clog2(HWL_LOCKS);

    typedef logic [HWL_TIDW-1:0]    tid_t;
    typedef logic [HWL_LIDW-1:0]    lid_t;
    typedef logic [HWL_THREADS-1:0] tmask_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ACQ  = 2'd1,
        OP_REL  = 2'd2
    } op_e;

    typedef struct packed {
        op_e  op;
        lid_t lock;
        tid_t tid;
    } req_t;

    typedef struct packed {
        logic   held;
        tid_t   owner;
        tmask_t waiters;
    } lock_t;

    function automatic tmask_t tid_bit(tid_t t);
        return tmask_t'(1) << t;
    endfunction

    // first set bit of m, scanning upward from start with wraparound
    function automatic tid_t rr_pick(tmask_t m, int start);
        tid_t pick;
        logic found;
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < HWL_THREADS; i++) begin
            int idx;
            idx = (start + i) % HWL_THREADS;
            if (!found && m[idx]) begin
                pick  = tid_t'(idx);
                found = 1'b1;
            end
        end
        return pick;
    endfunction
endpackage

// File: rtl/hwl_req_decode.sv
module hwl_req_decode import hwl_pkg::*; (
    input  logic acq_flag,
    input  logic rel_flag,
    input  lid_t lock,
    input  tid_t tid,
    output req_t req
);
    always_comb begin
        req.lock = lock;
        req.tid  = tid;
        unique case ({acq_flag, rel_flag})
            2'b10:   req.op = OP_ACQ;
            2'b01:   req.op = OP_REL;
            default: req.op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/hwl_lock_slot.sv
module hwl_lock_slot import hwl_pkg::*; #(
    parameter int SLOT_ID = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  req_t [HWL_CORES-1:0] reqs,
    output logic [HWL_CORES-1:0] grant,
    output logic [HWL_CORES-1:0] bad_rel,
    output logic                 wake,
    output tid_t                 wake_tid
);
    lock_t cur_q, nxt;
    logic [HWL_CORES-1:0] acq_hit, rel_hit, rel_ok;
    tmask_t acq_bits, pool;
    logic   first_found;
    tid_t   first_tid, handoff;

    always_comb begin
        acq_bits    = '0;
        first_found = 1'b0;
        first_tid   = '0;
        for (int c = 0; c < HWL_CORES; c++) begin
            acq_hit[c] = (reqs[c].op == OP_ACQ) && (reqs[c].lock == lid_t'(SLOT_ID));
            rel_hit[c] = (reqs[c].op == OP_REL) && (reqs[c].lock == lid_t'(SLOT_ID));
            rel_ok[c]  = rel_hit[c] && cur_q.held && (cur_q.owner == reqs[c].tid);
            bad_rel[c] = rel_hit[c] && !rel_ok[c];
            if (acq_hit[c]) begin
                acq_bits = acq_bits | tid_bit(reqs[c].tid);
                if (!first_found) begin
                    first_found = 1'b1;
                    first_tid   = reqs[c].tid;
                end
            end
        end
        pool    = cur_q.waiters | acq_bits;
        handoff = rr_pick(pool, int'(cur_q.owner) + 1);

        nxt      = cur_q;
        wake     = 1'b0;
        wake_tid = handoff;
        if (|rel_ok) begin
            if (|pool) begin
                nxt.held    = 1'b1;
                nxt.owner   = handoff;
                nxt.waiters = pool & ~tid_bit(handoff);
                wake        = !acq_bits[handoff];
            end else begin
                nxt = lock_t'('0);
            end
        end else if (!cur_q.held) begin
            if (first_found) begin
                nxt.held    = 1'b1;
                nxt.owner   = first_tid;
                nxt.waiters = acq_bits & ~tid_bit(first_tid);
            end
        end else begin
            nxt.waiters = pool & ~tid_bit(cur_q.owner);
        end

        for (int c = 0; c < HWL_CORES; c++)
            grant[c] = acq_hit[c] && nxt.held && (nxt.owner == reqs[c].tid);
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= lock_t'('0);
        else     cur_q <= nxt;
    end

    // R4: waiters only exist behind an owner
    a_r4_waiters_need_owner: assert property (@(posedge clk) disable iff (rst)
        !cur_q.held |-> (cur_q.waiters == '0));

    // R5: the owner is never also listed as waiting
    a_r5_owner_not_waiting: assert property (@(posedge clk) disable iff (rst)
        cur_q.held |-> !cur_q.waiters[cur_q.owner]);

    // R6: a legal release with nobody waiting frees the lock
    a_r6_free_after_last_release: assert property (@(posedge clk) disable iff (rst)
        ((|rel_ok) && (pool == '0)) |=> !cur_q.held);

    // R9: one lock is never granted to two cores at once
    a_r9_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
endmodule

// File: rtl/hwl_wake_queue.sv
module hwl_wake_queue import hwl_pkg::*; (
    input  logic                 clk,
    input  logic                 rst,
    input  tmask_t               wake_set,
    output logic [HWL_CORES-1:0] wake_valid,
    output tid_t [HWL_CORES-1:0] wake_tid
);
    tmask_t pend_q, pend_next, emit;
    logic [HWL_CORES-1:0] emit_v;
    tid_t [HWL_CORES-1:0] emit_tid;

    assign pend_next = pend_q | wake_set;

    always_comb begin
        emit     = '0;
        emit_v   = '0;
        emit_tid = '0;
        for (int c = 0; c < HWL_CORES; c++) begin
            for (int k = HWL_TPC - 1; k >= 0; k--) begin
                if (pend_next[c*HWL_TPC + k]) begin
                    emit_v[c]   = 1'b1;
                    emit_tid[c] = tid_t'(c*HWL_TPC + k);
                end
            end
            if (emit_v[c]) emit = emit | tid_bit(emit_tid[c]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= '0;
            wake_valid <= '0;
            wake_tid   <= '0;
        end else begin
            pend_q     <= pend_next & ~emit;
            wake_valid <= emit_v;
            wake_tid   <= emit_tid;
        end
    end

    for (genvar c = 0; c < HWL_CORES; c++) begin : g_chk
        // R10: a deferred wake is issued on the next cycle
        a_r10_pending_drains: assert property (@(posedge clk) disable iff (rst)
            (|pend_q[c*HWL_TPC +: HWL_TPC]) |=> wake_valid[c]);
    end
endmodule

// File: rtl/hwl_lock_arbiter.sv
module hwl_lock_arbiter import hwl_pkg::*; (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [HWL_CORES-1:0]                 req_acq_flag,
    input  logic [HWL_CORES-1:0]                 req_rel_flag,
    input  logic [HWL_CORES-1:0][HWL_LIDW-1:0]   req_lock,
    input  logic [HWL_CORES-1:0][HWL_TIDW-1:0]   req_tid,
    output logic [HWL_CORES-1:0]                 rsp_valid,
    output logic [HWL_CORES-1:0]                 rsp_grant,
    output logic [HWL_CORES-1:0]                 wake_valid,
    output logic [HWL_CORES-1:0][HWL_TIDW-1:0]   wake_tid,
    output logic                                 rel_error
);
    req_t [HWL_CORES-1:0] reqs;
    logic [HWL_CORES-1:0] s_grant [HWL_LOCKS];
    logic [HWL_CORES-1:0] s_bad   [HWL_LOCKS];
    logic                 s_wake  [HWL_LOCKS];
    tid_t                 s_wtid  [HWL_LOCKS];
    logic [HWL_CORES-1:0] grant_any, bad_any, acq_now;
    tmask_t               wake_set;
    tid_t [HWL_CORES-1:0] q_tid;

    for (genvar c = 0; c < HWL_CORES; c++) begin : g_dec
        hwl_req_decode u_dec (
            .acq_flag (req_acq_flag[c]),
            .rel_flag (req_rel_flag[c]),
            .lock     (req_lock[c]),
            .tid      (req_tid[c]),
            .req      (reqs[c])
        );
    end

    for (genvar s = 0; s < HWL_LOCKS; s++) begin : g_slot
        hwl_lock_slot #(.SLOT_ID(s)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .reqs     (reqs),
            .grant    (s_grant[s]),
            .bad_rel  (s_bad[s]),
            .wake     (s_wake[s]),
            .wake_tid (s_wtid[s])
        );
    end

    always_comb begin
        grant_any = '0;
        bad_any   = '0;
        wake_set  = '0;
        for (int s = 0; s < HWL_LOCKS; s++) begin
            grant_any = grant_any | s_grant[s];
            bad_any   = bad_any | s_bad[s];
            if (s_wake[s]) wake_set = wake_set | tid_bit(s_wtid[s]);
        end
        for (int c = 0; c < HWL_CORES; c++)
            acq_now[c] = (reqs[c].op == OP_ACQ);
    end

    hwl_wake_queue u_wq (
        .clk        (clk),
        .rst        (rst),
        .wake_set   (wake_set),
        .wake_valid (wake_valid),
        .wake_tid   (q_tid)
    );
    assign wake_tid = q_tid;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= '0;
            rsp_grant <= '0;
            rel_error <= 1'b0;
        end else begin
            rsp_valid <= acq_now;
            rsp_grant <= grant_any & acq_now;
            rel_error <= rel_error | (|bad_any);
        end
    end

    for (genvar c = 0; c < HWL_CORES; c++) begin : g_chk
        // R3: an answer only follows an acquire on the same core
        a_r3_rsp_after_acquire: assert property (@(posedge clk) disable iff (rst)
            rsp_valid[c] |-> $past(req_acq_flag[c] && !req_rel_flag[c]));
        // R2: both flags set yields no answer
        a_r2_both_flags_idle: assert property (@(posedge clk) disable iff (rst)
            (req_acq_flag[c] && req_rel_flag[c]) |=> !rsp_valid[c]);
    end

    // R7: the error flag never clears outside reset
    a_r7_error_sticky: assert property (@(posedge clk) disable iff (rst)
        rel_error |=> rel_error);
endmodule

// File: tb/hwl_lock_arbiter_test.sv
module hwl_lock_arbiter_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0]      acq_f = '0;
    logic [1:0]      rel_f = '0;
    logic [1:0][3:0] lk    = '0;
    logic [1:0][2:0] td    = '0;
    logic [1:0]      rsp_valid, rsp_grant, wake_valid;
    logic [1:0][2:0] wake_tid;
    logic            rel_error;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam int ACQ = 1, REL = 2, BOTH = 3;

    always #10 clk = ~clk;

    hwl_lock_arbiter uut (
        .clk(clk), .rst(rst),
        .req_acq_flag(acq_f), .req_rel_flag(rel_f),
        .req_lock(lk), .req_tid(td),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .wake_valid(wake_valid), .wake_tid(wake_tid),
        .rel_error(rel_error)
    );

    task automatic chk(bit ok, string r, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    task automatic drive(int c, int kind, int lock, int tid);
        acq_f[c] = (kind == ACQ) || (kind == BOTH);
        rel_f[c] = (kind == REL) || (kind == BOTH);
        lk[c]    = 4'(lock);
        td[c]    = 3'(tid);
    endtask

    // outputs for inputs driven now are sampled at the following falling edge
    task automatic step();
        @(negedge clk);
        acq_f = '0;
        rel_f = '0;
    endtask

    task automatic exp_rsp(string r, int c, bit v, bit g);
        chk(rsp_valid[c] == v, r, $sformatf("rsp_valid core%0d", c), rsp_valid[c], v);
        if (v) chk(rsp_grant[c] == g, r, $sformatf("rsp_grant core%0d", c), rsp_grant[c], g);
    endtask

    task automatic exp_wake(string r, int c, bit v, int t);
        chk(wake_valid[c] == v, r, $sformatf("wake_valid core%0d", c), wake_valid[c], v);
        if (v) chk(wake_tid[c] == 3'(t), r, $sformatf("wake_tid core%0d", c), wake_tid[c], t);
    endtask

    task automatic acquire(string r, int lock, int tid, bit g);
        drive(tid / 4, ACQ, lock, tid);
        step();
        exp_rsp(r, tid / 4, 1'b1, g);
    endtask

    task automatic release_ok(string r, int lock, int tid);
        drive(tid / 4, REL, lock, tid);
        step();
    endtask

    initial begin : main
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        for (int c = 0; c < 2; c++) begin
            exp_rsp("R1", c, 1'b0, 1'b0);
            exp_wake("R1", c, 1'b0, 0);
        end
        chk(rel_error == 1'b0, "R1", "rel_error", rel_error, 0);
        step();
        exp_rsp("R1", 0, 1'b0, 1'b0);

        // R3 R4 R5 R6 R11: every lock, every first owner, full handoff chain
        for (int L = 0; L < 16; L++) begin
            for (int o = 0; o < 8; o++) begin
                int cur;
                acquire("R3", L, o, 1'b1);
                exp_rsp("R3", 1 - o / 4, 1'b0, 1'b0);
                for (int k = 7; k >= 1; k--) acquire("R4", L, (o + k) % 8, 1'b0);
                cur = o;
                for (int k = 1; k < 8; k++) begin
                    int nx;
                    nx = (o + k) % 8;
                    release_ok("R5", L, cur);
                    exp_wake("R5", nx / 4, 1'b1, nx);
                    exp_wake("R5", 1 - nx / 4, 1'b0, 0);
                    cur = nx;
                end
                release_ok("R6", L, cur);
                exp_wake("R6", 0, 1'b0, 0);
                exp_wake("R6", 1, 1'b0, 0);
            end
        end
        chk(rel_error == 1'b0, "R7", "rel_error after legal releases", rel_error, 0);

        // R2: both flags is no operation
        drive(0, BOTH, 2, 0);
        step();
        exp_rsp("R2", 0, 1'b0, 1'b0);
        acquire("R2", 2, 1, 1'b1);
        drive(0, 0, 2, 1);
        step();
        exp_rsp("R2", 0, 1'b0, 1'b0);
        release_ok("R2", 2, 1);

        // R7: release by a non-owner
        acquire("R7", 3, 2, 1'b1);
        release_ok("R7", 3, 5);
        exp_wake("R7", 0, 1'b0, 0);
        exp_wake("R7", 1, 1'b0, 0);
        chk(rel_error == 1'b1, "R7", "rel_error set", rel_error, 1);
        acquire("R7", 3, 7, 1'b0);
        release_ok("R7", 3, 2);
        exp_wake("R7", 1, 1'b1, 7);
        step();
        chk(rel_error == 1'b1, "R7", "rel_error sticky", rel_error, 1);
        release_ok("R7", 3, 7);

        // R8: release and acquire in one cycle, acquirer wins
        acquire("R8", 5, 1, 1'b1);
        acquire("R8", 5, 6, 1'b0);
        drive(0, REL, 5, 1);
        drive(1, ACQ, 5, 4);
        step();
        exp_rsp("R8", 1, 1'b1, 1'b1);
        exp_wake("R8", 0, 1'b0, 0);
        exp_wake("R8", 1, 1'b0, 0);
        // R8: release and acquire in one cycle, waiter wins
        drive(1, REL, 5, 4);
        drive(0, ACQ, 5, 0);
        step();
        exp_rsp("R8", 0, 1'b1, 1'b0);
        exp_wake("R8", 1, 1'b1, 6);
        release_ok("R8", 5, 6);
        exp_wake("R8", 0, 1'b1, 0);
        release_ok("R8", 5, 0);

        // R9: both cores acquire a free lock
        drive(0, ACQ, 7, 1);
        drive(1, ACQ, 7, 5);
        step();
        exp_rsp("R9", 0, 1'b1, 1'b1);
        exp_rsp("R9", 1, 1'b1, 1'b0);
        release_ok("R9", 7, 1);
        exp_wake("R9", 1, 1'b1, 5);
        release_ok("R9", 7, 5);

        // R10 R11: two wakes for core 0 from two locks in one cycle
        acquire("R10", 8, 0, 1'b1);
        acquire("R10", 8, 1, 1'b0);
        acquire("R11", 9, 4, 1'b1);
        acquire("R11", 9, 2, 1'b0);
        drive(0, REL, 8, 0);
        drive(1, REL, 9, 4);
        step();
        exp_wake("R10", 0, 1'b1, 1);
        exp_wake("R10", 1, 1'b0, 0);
        step();
        exp_wake("R10", 0, 1'b1, 2);
        step();
        exp_wake("R10", 0, 1'b0, 0);

        // R1: reset clears the sticky flag and the locks
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk(rel_error == 1'b0, "R1", "rel_error after reset", rel_error, 0);
        acquire("R1", 9, 2, 1'b1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule